// File: doc/BRIEF.md
# Static Memory Access Timing Sequencer

This block runs one external static-memory or burst-ROM access at a time and shapes its timing for the memory area that was addressed. Each area has its own configuration inputs: a first-access wait code, a burst-pitch code, a burst mode code, an inter-cycle idle count, a write-strobe setup bit and a data hold field. On an accepted start request, the block copies the selected area's timing into internal registers and then steps through the beats of the access. It drives a chip select, a read strobe and a write strobe, and it steps the low address bits once per beat.

At the end it raises a one-cycle completion pulse. It then holds off the next request for the area's idle count. Only some areas can burst, and a parameter mask chooses which ones. Every other area always performs a single beat.

Top module: `smem_timing_seq`

## Requirements
- R1: The first beat's strobe lasts 1 + N cycles, where N comes from the 3-bit wait code: 0→0, 1→1, 2→2, 3→3, 4→6, 5→9, 6→12, 7→15.
- R2: Every beat after the first has a strobe lasting 1 + P cycles, where P is the 3-bit pitch code used as a plain number.
- R3: For a burst-capable area (areas 0, 5 and 6 by default), burst code 1, 2, 3 or 4 gives 4, 8, 16 or 32 beats. Code 0, the reserved codes 5 to 7, and every area without burst capability give exactly one beat, and the pitch code has no effect there.
- R4: On a write whose area has the setup bit set, each beat begins with one cycle in which chip select is high and both strobes are low. Reads never get this cycle.
- R5: On a write, each beat's strobe is followed by H cycles with chip select high and both strobes low, where H is the 2-bit hold field. Reads have no hold cycles.
- R6: Chip select stays high for every cycle from the cycle after acceptance to the last cycle of the access. The read strobe is high only in strobe cycles of reads. The write strobe is high only in strobe cycles of writes. The two strobes are never high together.
- R7: `access_done` is high for exactly one cycle, which is the last cycle of the access (the final strobe cycle, or the final hold cycle when H > 0).
- R8: After the access, chip select falls and `start_ready` stays low for I cycles, where I is the 3-bit idle field. After that, `start_ready` is high. It is high right after reset and low during every cycle of an access.
- R9: The address low bits start at the request address and increment once per completed beat, wrapping within an aligned window of the burst length. All other address bits keep their request value.
- R10: The timing configuration is captured in the cycle the request is accepted. Configuration changes made during the access do not change its waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Start request, accepted when start_ready is high |
| start_area | input | AREA_W | Area index of the request |
| start_write | input | 1 | 1 = write, 0 = read |
| start_addr | input | ADDR_W | Start address |
| start_ready | output | 1 | Block idle and able to accept |
| cfg_wait_code | input | NUM_AREAS*3 | First-access wait code per area (area n at bits 3n+2:3n) |
| cfg_pitch_code | input | NUM_AREAS*3 | Burst pitch code per area |
| cfg_burst_code | input | NUM_AREAS*3 | Burst mode code per area |
| cfg_idle | input | NUM_AREAS*3 | Idle cycles after the access, per area |
| cfg_setup | input | NUM_AREAS | Write setup bit per area |
| cfg_hold | input | NUM_AREAS*2 | Write hold cycles per area |
| mem_cs | output | 1 | Chip select, active high |
| mem_rd | output | 1 | Read strobe, active high |
| mem_wr | output | 1 | Write strobe, active high |
| mem_addr | output | ADDR_W | Current beat address |
| access_done | output | 1 | One-cycle completion pulse |

## Verification
Several events can land in the same clock edge. The end of the final beat, the completion pulse, and the start of the idle window (or the return of `start_ready` when the idle count is zero) all happen together. In the middle of a burst, the end of one beat, the address wrap and the reload of the pitch count also happen together. The bench provokes both cases with bursts whose start address lies near the top of the wrap window, and with back-to-back requests that use zero idle and zero hold. A cycle-by-cycle expected waveform is compared every cycle, so a pulse, wrap or ready signal that arrives one cycle early or late is reported.

// File: rtl/smt_pkg.sv
package smt_pkg;

   localparam int unsigned CODE_W = 3;
   localparam int unsigned CNT_W  = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_STROBE,
      ST_HOLD,
      ST_GAP
   } smt_state_e;

   typedef struct packed {
      logic [CNT_W-1:0]  first_wait;
      logic [CODE_W-1:0] pitch;
      logic [2:0]        len_log;
      logic [CODE_W-1:0] idle;
      logic              setup;
      logic [1:0]        hold;
   } smt_timing_t;

   // Codes 0..3 are taken as-is; codes above 3 grow in steps of three.
   function automatic logic [CNT_W-1:0] decode_wait(input logic [CODE_W-1:0] code);
      logic [CNT_W-1:0] wide;
      wide = {1'b0, code};
      if (code < 3'd4) return wide;
      return CNT_W'(3 * (wide - 4'd2));
   endfunction

   // Returns log2 of the beat count; reserved codes give a single beat.
   function automatic logic [2:0] burst_log(input logic [CODE_W-1:0] code);
      case (code)
         3'd1:    return 3'd2;
         3'd2:    return 3'd3;
         3'd3:    return 3'd4;
         3'd4:    return 3'd5;
         default: return 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/smt_cfg_select.sv
module smt_cfg_select
   import smt_pkg::*;
#(
   parameter int unsigned NUM_AREAS  = 7,
   parameter int unsigned AREA_W     = 3,
   parameter logic [NUM_AREAS-1:0] BURST_MASK = 7'b110_0001
) (
   input  logic [AREA_W-1:0]           area,
   input  logic [NUM_AREAS*CODE_W-1:0] cfg_wait_code,
   input  logic [NUM_AREAS*CODE_W-1:0] cfg_pitch_code,
   input  logic [NUM_AREAS*CODE_W-1:0] cfg_burst_code,
   input  logic [NUM_AREAS*CODE_W-1:0] cfg_idle,
   input  logic [NUM_AREAS-1:0]        cfg_setup,
   input  logic [NUM_AREAS*2-1:0]      cfg_hold,
   output smt_timing_t                 timing
);

   smt_timing_t per_area [NUM_AREAS];

   for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
      if (BURST_MASK[g]) begin : g_burst
         assign per_area[g] = '{
            first_wait: decode_wait(cfg_wait_code[g*CODE_W +: CODE_W]),
            pitch:      cfg_pitch_code[g*CODE_W +: CODE_W],
            len_log:    burst_log(cfg_burst_code[g*CODE_W +: CODE_W]),
            idle:       cfg_idle[g*CODE_W +: CODE_W],
            setup:      cfg_setup[g],
            hold:       cfg_hold[g*2 +: 2]
         };
      end else begin : g_single
         logic unused_burst_bits;
         assign unused_burst_bits = ^{cfg_pitch_code[g*CODE_W +: CODE_W],
                                      cfg_burst_code[g*CODE_W +: CODE_W]};
         assign per_area[g] = '{
            first_wait: decode_wait(cfg_wait_code[g*CODE_W +: CODE_W]),
            pitch:      '0,
            len_log:    '0,
            idle:       cfg_idle[g*CODE_W +: CODE_W],
            setup:      cfg_setup[g],
            hold:       cfg_hold[g*2 +: 2]
         };
      end
   end

   always_comb begin
      timing = '0;
      for (int i = 0; i < NUM_AREAS; i++) begin
         if (AREA_W'(i) == area) timing = per_area[i];
      end
   end

endmodule

// File: rtl/smt_beat_ctr.sv
module smt_beat_ctr #(
   parameter int unsigned LOW_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             advance,
   input  logic [LOW_W-1:0] load_low,
   input  logic [2:0]       load_log,
   output logic [LOW_W-1:0] low_addr,
   output logic             last_beat
);

   if (LOW_W < 5) begin : g_chk_low
      $error("LOW_W must cover a 32-beat window");
   end

   logic [LOW_W-1:0] idx_q, low_q, mask_q;
   logic [LOW_W:0]   one_hot;

   assign one_hot = (LOW_W+1)'(1) << load_log;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         low_q  <= '0;
         mask_q <= '0;
      end else if (load) begin
         idx_q  <= '0;
         low_q  <= load_low;
         mask_q <= LOW_W'(one_hot - 1'b1);
      end else if (advance) begin
         idx_q  <= idx_q + 1'b1;
         low_q  <= (low_q & ~mask_q) | ((low_q + 1'b1) & mask_q);
      end
   end

   assign low_addr  = low_q;
   assign last_beat = (idx_q == mask_q);

   // R9: low bits move only when a beat completes or a new access loads
   p_low_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !advance) |=> $stable(low_addr));

   // R9: bits outside the burst window survive every increment
   p_upper_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !load) |=> ((low_addr & ~mask_q) == $past(low_addr & ~mask_q)));

endmodule

// File: rtl/smem_timing_seq.sv
module smem_timing_seq
   import smt_pkg::*;
#(
   parameter int unsigned NUM_AREAS  = 7,
   parameter int unsigned AREA_W     = 3,
   parameter int unsigned ADDR_W     = 26,
   parameter logic [NUM_AREAS-1:0] BURST_MASK = 7'b110_0001
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start_valid,
   input  logic [AREA_W-1:0]           start_area,
   input  logic                        start_write,
   input  logic [ADDR_W-1:0]           start_addr,
   output logic                        start_ready,
   input  logic [NUM_AREAS*3-1:0]      cfg_wait_code,
   input  logic [NUM_AREAS*3-1:0]      cfg_pitch_code,
   input  logic [NUM_AREAS*3-1:0]      cfg_burst_code,
   input  logic [NUM_AREAS*3-1:0]      cfg_idle,
   input  logic [NUM_AREAS-1:0]        cfg_setup,
   input  logic [NUM_AREAS*2-1:0]      cfg_hold,
   output logic                        mem_cs,
   output logic                        mem_rd,
   output logic                        mem_wr,
   output logic [ADDR_W-1:0]           mem_addr,
   output logic                        access_done
);

   localparam int unsigned LOW_W = 5;

   if (ADDR_W <= LOW_W) begin : g_chk_addr
      $error("ADDR_W must exceed the burst window width");
   end
   if (NUM_AREAS > (1 << AREA_W)) begin : g_chk_area
      $error("AREA_W too narrow for NUM_AREAS");
   end

   smt_timing_t        timing;
   smt_state_e         state_q, state_n;
   logic [CNT_W-1:0]   cnt_q, cnt_n;
   logic [CODE_W-1:0]  pitch_q, idle_q;
   logic               setup_q, write_q;
   logic [1:0]         hold_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [LOW_W-1:0]   low_addr;
   logic               last_beat, accept, beat_end, advance;

   smt_cfg_select #(
      .NUM_AREAS (NUM_AREAS),
      .AREA_W    (AREA_W),
      .BURST_MASK(BURST_MASK)
   ) u_cfg (
      .area          (start_area),
      .cfg_wait_code (cfg_wait_code),
      .cfg_pitch_code(cfg_pitch_code),
      .cfg_burst_code(cfg_burst_code),
      .cfg_idle      (cfg_idle),
      .cfg_setup     (cfg_setup),
      .cfg_hold      (cfg_hold),
      .timing        (timing)
   );

   assign accept   = (state_q == ST_IDLE) && start_valid;
   assign beat_end = ((state_q == ST_STROBE) && (cnt_q == '0) && !(write_q && (hold_q != 2'd0)))
                   || ((state_q == ST_HOLD) && (cnt_q == '0));
   assign advance  = beat_end && !last_beat;

   smt_beat_ctr #(.LOW_W(LOW_W)) u_beat (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .advance  (advance),
      .load_low (start_addr[LOW_W-1:0]),
      .load_log (timing.len_log),
      .low_addr (low_addr),
      .last_beat(last_beat)
   );

   always_comb begin
      state_n = state_q;
      cnt_n   = cnt_q;
      unique case (state_q)
         ST_IDLE: begin
            if (start_valid) begin
               state_n = (start_write && timing.setup) ? ST_SETUP : ST_STROBE;
               cnt_n   = timing.first_wait;
            end
         end
         ST_SETUP: state_n = ST_STROBE;
         ST_STROBE: begin
            if (cnt_q != '0) begin
               cnt_n = cnt_q - 1'b1;
            end else if (write_q && (hold_q != 2'd0)) begin
               state_n = ST_HOLD;
               cnt_n   = CNT_W'(hold_q - 2'd1);
            end
         end
         ST_HOLD: begin
            if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
         end
         ST_GAP: begin
            if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
            else             state_n = ST_IDLE;
         end
         default: state_n = ST_IDLE;
      endcase
      if (beat_end) begin
         if (last_beat) begin
            state_n = (idle_q != '0) ? ST_GAP : ST_IDLE;
            cnt_n   = CNT_W'(idle_q - 1'b1);
         end else begin
            state_n = (write_q && setup_q) ? ST_SETUP : ST_STROBE;
            cnt_n   = CNT_W'(pitch_q);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         pitch_q <= '0;
         idle_q  <= '0;
         setup_q <= 1'b0;
         hold_q  <= '0;
         write_q <= 1'b0;
         addr_q  <= '0;
      end else begin
         state_q <= state_n;
         cnt_q   <= cnt_n;
         if (accept) begin
            pitch_q <= timing.pitch;
            idle_q  <= timing.idle;
            setup_q <= timing.setup;
            hold_q  <= timing.hold;
            write_q <= start_write;
            addr_q  <= start_addr;
         end
      end
   end

   assign start_ready = (state_q == ST_IDLE);
   assign mem_cs      = (state_q == ST_SETUP) || (state_q == ST_STROBE) || (state_q == ST_HOLD);
   assign mem_rd      = (state_q == ST_STROBE) && !write_q;
   assign mem_wr      = (state_q == ST_STROBE) && write_q;
   assign mem_addr    = {addr_q[ADDR_W-1:LOW_W], low_addr};
   assign access_done = beat_end && last_beat;

   p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   p_strobe_in_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> mem_cs);

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      access_done |=> !access_done);

   p_done_ends_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      access_done |=> !mem_cs);

   p_ready_no_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_ready |-> !mem_cs);

   p_gap_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (access_done && (idle_q != '0)) |=> !start_ready);

   p_setup_leads_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SETUP) |=> mem_wr);

   p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cs && $past(mem_cs)) |-> ($stable(pitch_q) && $stable(idle_q) &&
                                     $stable(hold_q) && $stable(setup_q) && $stable(write_q)));

endmodule

// File: tb/test_smem_timing_seq.sv
module test_smem_timing_seq;

   localparam int NA = 7;
   localparam int AW = 26;
   localparam logic [NA-1:0] CAP = 7'b110_0001;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_valid = 1'b0;
   logic [2:0]    start_area = '0;
   logic          start_write = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic          start_ready, mem_cs, mem_rd, mem_wr, access_done;
   logic [AW-1:0] mem_addr;
   logic [NA*3-1:0] cfg_wait_code, cfg_pitch_code, cfg_burst_code, cfg_idle;
   logic [NA-1:0]   cfg_setup;
   logic [NA*2-1:0] cfg_hold;

   logic [2:0] wcode [NA];
   logic [2:0] pcode [NA];
   logic [2:0] bcode [NA];
   logic [2:0] icode [NA];
   logic       su    [NA];
   logic [1:0] hd    [NA];

   always_comb begin
      for (int i = 0; i < NA; i++) begin
         cfg_wait_code[i*3 +: 3]  = wcode[i];
         cfg_pitch_code[i*3 +: 3] = pcode[i];
         cfg_burst_code[i*3 +: 3] = bcode[i];
         cfg_idle[i*3 +: 3]       = icode[i];
         cfg_setup[i]             = su[i];
         cfg_hold[i*2 +: 2]       = hd[i];
      end
   end

   always #4 clk = ~clk;

   smem_timing_seq i_smem_timing_seq (
      .clk(clk), .rst_n(rst_n),
      .start_valid(start_valid), .start_area(start_area), .start_write(start_write),
      .start_addr(start_addr), .start_ready(start_ready),
      .cfg_wait_code(cfg_wait_code), .cfg_pitch_code(cfg_pitch_code),
      .cfg_burst_code(cfg_burst_code), .cfg_idle(cfg_idle),
      .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
      .mem_cs(mem_cs), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_addr(mem_addr), .access_done(access_done)
   );

   typedef struct {
      logic          cs, rd, wr, done, rdy;
      logic [AW-1:0] addr;
      string         tag;
   } exp_t;

   exp_t q[$];
   int   n_vec  = 0;
   int   n_fail = 0;

   function automatic int wait_of(input logic [2:0] c);
      int t [8] = '{0, 1, 2, 3, 6, 9, 12, 15};
      return t[c];
   endfunction

   function automatic int beats_of(input int area);
      if (!CAP[area]) return 1;
      case (bcode[area])
         3'd1: return 4;
         3'd2: return 8;
         3'd3: return 16;
         3'd4: return 32;
         default: return 1;
      endcase
   endfunction

   task automatic push(input logic cs, rd, wr, done, rdy, input logic [AW-1:0] a, input string tag);
      exp_t e;
      e.cs = cs; e.rd = rd; e.wr = wr; e.done = done; e.rdy = rdy; e.addr = a; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic scramble_cfg();
      for (int i = 0; i < NA; i++) begin
         wcode[i] = ~wcode[i]; pcode[i] = ~pcode[i]; bcode[i] = 3'd4;
         icode[i] = ~icode[i]; su[i] = ~su[i]; hd[i] = ~hd[i];
      end
   endtask

   // Driver: computes the expected waveform from the requirements and issues the request.
   task automatic access(input int area, input bit wr, input logic [AW-1:0] a,
                         input bit scramble, input string tag);
      int nb, fw, pw, hold, idle;
      bit setup;
      logic [4:0] mask, low;
      nb    = beats_of(area);
      fw    = wait_of(wcode[area]);
      pw    = CAP[area] ? int'(pcode[area]) : 0;
      setup = wr && su[area];
      hold  = wr ? int'(hd[area]) : 0;
      idle  = int'(icode[area]);
      mask  = 5'(nb - 1);
      @(negedge clk);
      while (!start_ready) @(negedge clk);
      for (int b = 0; b < nb; b++) begin
         int w;
         bit last;
         logic [AW-1:0] ab;
         w    = (b == 0) ? fw : pw;
         last = (b == nb - 1);
         low  = (a[4:0] & ~mask) | ((a[4:0] + 5'(b)) & mask);
         ab   = {a[AW-1:5], low};
         if (setup) push(1, 0, 0, 0, 0, ab, {tag, " R4"});
         for (int k = 0; k <= w; k++)
            push(1, !wr, wr, last && k == w && hold == 0, 0, ab,
                 (b == 0) ? {tag, " R1"} : {tag, " R2 R9"});
         for (int h = 0; h < hold; h++)
            push(1, 0, 0, last && h == hold - 1, 0, ab, {tag, " R5 R7"});
      end
      for (int g = 0; g < idle; g++) push(0, 0, 0, 0, 0, '0, {tag, " R8"});
      push(0, 0, 0, 0, 1, '0, {tag, " R8"});
      start_valid = 1'b1; start_area = 3'(area); start_write = wr; start_addr = a;
      @(negedge clk);
      start_valid = 1'b0;
      start_area  = 3'(area + 1);
      start_write = !wr;
      if (scramble) scramble_cfg();
      while (q.size() != 0) @(negedge clk);
   endtask

   // Monitor: compares one expected item per cycle, sampled after the edge.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if (mem_cs !== e.cs || mem_rd !== e.rd || mem_wr !== e.wr ||
                access_done !== e.done || start_ready !== e.rdy ||
                (e.cs && mem_addr !== e.addr)) begin
               n_fail++;
               $display("FAIL %s R6: cs/rd/wr/done/rdy/addr got %b%b%b%b%b %h exp %b%b%b%b%b %h",
                        e.tag, mem_cs, mem_rd, mem_wr, access_done, start_ready, mem_addr,
                        e.cs, e.rd, e.wr, e.done, e.rdy, e.addr);
            end
         end
      end
   end

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog R7: got hang, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   task automatic set_area(input int a, input logic [2:0] w, p, b, i, input logic s,
                           input logic [1:0] h);
      wcode[a] = w; pcode[a] = p; bcode[a] = b; icode[a] = i; su[a] = s; hd[a] = h;
   endtask

   initial begin
      for (int i = 0; i < NA; i++) set_area(i, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 2'd0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      n_vec++;
      if (mem_cs !== 1'b0 || start_ready !== 1'b1 || access_done !== 1'b0) begin
         n_fail++;
         $display("FAIL reset R8: cs/rdy/done got %b%b%b exp 010", mem_cs, start_ready, access_done);
      end

      // R1: wait code mapping, single read beats
      for (int c = 0; c < 8; c++) begin
         set_area(2, 3'(c), 3'd0, 3'd0, 3'(c % 3), 1'b0, 2'd0);
         access(2, 0, 26'h0012345, 0, "wait_sweep R1");
      end
      // R4 R5: write with setup and hold, long wait
      set_area(3, 3'd7, 3'd0, 3'd0, 3'd2, 1'b1, 2'd2);
      access(3, 1, 26'h0100003, 0, "write_setup_hold R4 R5");
      // R5: read ignores hold and setup
      access(3, 0, 26'h0100003, 0, "read_no_hold R5");
      // R2 R9: 4-beat read burst wrapping at the window top
      set_area(0, 3'd5, 3'd3, 3'd1, 3'd1, 1'b0, 2'd0);
      access(0, 0, 26'h00000A2, 0, "burst4 R2 R9");
      // R4 R5 R9: 8-beat write burst with setup and hold
      set_area(5, 3'd1, 3'd0, 3'd2, 3'd0, 1'b1, 2'd1);
      access(5, 1, 26'h000011D, 0, "burst8_write R9");
      // R7 R8: back-to-back with zero idle and zero hold
      set_area(5, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 2'd0);
      access(5, 1, 26'h0000040, 0, "b2b R7 R8");
      access(5, 0, 26'h0000041, 0, "b2b R7 R8");
      // R3: reserved burst codes act as single access
      for (int c = 5; c < 8; c++) begin
         set_area(6, 3'd2, 3'd7, 3'(c), 3'd1, 1'b0, 2'd0);
         access(6, 0, 26'h0000007, 0, "reserved R3");
      end
      // R3: area without burst capability ignores the burst code
      set_area(1, 3'd3, 3'd7, 3'd1, 3'd0, 1'b0, 2'd3);
      access(1, 0, 26'h0000003, 0, "nocap R3");
      // R3 R10: 32-beat read with configuration scrambled mid-access
      set_area(0, 3'd4, 3'd1, 3'd4, 3'd3, 1'b0, 2'd0);
      access(0, 0, 26'h3FFFFE5, 1, "burst32_scramble R10");
      // R3 R6: 16-beat write on area 6, no hold
      for (int i = 0; i < NA; i++) set_area(i, 3'd0, 3'd0, 3'd0, 3'd0, 1'b0, 2'd0);
      set_area(6, 3'd2, 3'd2, 3'd3, 3'd0, 1'b0, 2'd0);
      access(6, 1, 26'h000002C, 0, "burst16_write R3 R6");

      repeat (4) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule